// File: doc/BRIEF.md
# Quarter-Rate IF Sample I/Q Demodulator

This block takes real samples of an intermediate-frequency signal that was undersampled so that the wanted replica lands at one quarter of the sample rate. It brings that replica to baseband and splits it into in-phase and quadrature parts. The carrier frequency is assumed to be an odd multiple of fs/4, for example 3fs/4.

The complex mixing factor repeats every four samples. Because of that, each sample is only passed through or two's-complement negated, and then steered to one of the two arms. Even-indexed samples go to the I arm and odd-indexed samples go to the Q arm. The arm that does not receive the sample is given a zero in that slot, and no multiplier is used.

A build parameter selects decimation by two. In that mode the zero slots are dropped and one time-aligned I/Q pair leaves for every two accepted samples. A second build parameter selects a four-lane form. It accepts four consecutive samples per clock, gives each lane a fixed sign and arm, and so runs at a quarter of the sample rate.

Top module: `iq_quarter_demod`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_i` and `out_q` are cleared to zero on that edge. The first sample accepted after reset is given sample index n=0.
- R2: Serial mode without decimation mixes by a phase taken from the sample index, n mod 4. Phase 0 gives I=+x and Q=0. Phase 1 gives I=0 and Q=-x. Phase 2 gives I=-x and Q=0. Phase 3 gives I=0 and Q=+x. The result appears with `out_valid` high one clock after the sample is accepted.
- R3: Outputs are signed two's complement and DATA_W+1 bits wide. An input of -2^(DATA_W-1) on a negated phase comes out as exactly +2^(DATA_W-1). No output ever equals -2^DATA_W.
- R4: In serial decimating mode, `out_valid` pulses once for every two accepted samples, one clock after the odd-indexed sample. Each pulse carries I = sign·x[2m] and Q = sign·x[2m+1], with the signs of R2. `out_valid` is never high on two consecutive clocks.
- R5: The sample index advances only on clocks where `in_valid` is high. Idle clocks between samples leave the mixing sequence unchanged.
- R6: In four-lane mode, lane k (input bits k·DATA_W upward) holds sample index 4m+k. Without decimation, output pair k (bits k·(DATA_W+1) upward on `out_i` and `out_q`) is lane k mixed by phase k. The outputs are registered one clock after an accepted word.
- R7: In four-lane decimating mode, pair 0 is I=+x0, Q=-x1 and pair 1 is I=-x2, Q=+x3. Both pairs leave together one clock after the word is accepted.
- R8: `out_valid` is low on any clock that follows a clock with no accepted input. While `out_valid` is low, `out_i` and `out_q` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word holds new samples |
| in_data | input | LANES·DATA_W | Input samples; lane 0 in the low bits (LANES is 1, or 4 in four-lane mode) |
| out_valid | output | 1 | Output pairs are new this clock |
| out_i | output | PAIRS·(DATA_W+1) | In-phase results; pair 0 in the low bits |
| out_q | output | PAIRS·(DATA_W+1) | Quadrature results; pair 0 in the low bits |

## Verification
The bench runs four configurations side by side: serial and four-lane, each with and without decimation. All four are compared against an index-driven arithmetic model on every clock.

A contiguous ramp makes every sample distinct, so it exposes swapped arms, wrong signs and pairs taken from the wrong slots. Streams with idle gaps show whether the phase drifts when no sample is accepted. Full-scale extremes show whether negating the most negative value overflows. A reset placed mid-sequence after an odd number of samples shows that index zero restarts correctly. Long random streams with random valid spacing then mix all of these effects together.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

    localparam int SAMPLE_W  = 8;
    localparam int PHASE_CNT = 4;

    typedef enum logic [1:0] {
        PH_POS_I = 2'd0,
        PH_NEG_Q = 2'd1,
        PH_NEG_I = 2'd2,
        PH_POS_Q = 2'd3
    } phase_e;

    typedef struct packed {
        logic to_q;
        logic negate;
    } mix_ctl_t;

    function automatic mix_ctl_t decode_phase(phase_e ph);
        mix_ctl_t c;
        c.to_q   = ph[0];
        c.negate = (ph == PH_NEG_Q) || (ph == PH_NEG_I);
        return c;
    endfunction

    function automatic phase_e next_phase(phase_e ph);
        return phase_e'(ph + 2'd1);
    endfunction

endpackage

// File: rtl/iqd_phase.sv
module iqd_phase
    import iqd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output phase_e ph
);

    always_ff @(posedge clk) begin
        if (rst)
            ph <= PH_POS_I;
        else if (adv)
            ph <= next_phase(ph);
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ph)); // R5

endmodule

// File: rtl/iqd_lane.sv
module iqd_lane
    import iqd_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W,
    localparam int OUT_W = DATA_W + 1
) (
    input  phase_e                   ph,
    input  logic [DATA_W-1:0]        x,
    output logic signed [OUT_W-1:0]  i_o,
    output logic signed [OUT_W-1:0]  q_o
);

    mix_ctl_t                 ctl;
    logic signed [OUT_W-1:0]  ext;
    logic signed [OUT_W-1:0]  mag;

    always_comb begin
        ctl = decode_phase(ph);
        ext = $signed({x[DATA_W-1], x});
        mag = ctl.negate ? -ext : ext;
        i_o = ctl.to_q ? '0 : mag;
        q_o = ctl.to_q ? mag : '0;
    end

endmodule

// File: rtl/iq_quarter_demod.sv
module iq_quarter_demod
    import iqd_pkg::*;
#(
    parameter int DATA_W   = SAMPLE_W,
    parameter bit PARALLEL = 1'b0,
    parameter bit DECIMATE = 1'b1,
    localparam int OUT_W     = DATA_W + 1,
    localparam int LANES     = PARALLEL ? PHASE_CNT : 1,
    localparam int OUT_PAIRS = PARALLEL ? (DECIMATE ? PHASE_CNT / 2 : PHASE_CNT) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [LANES*DATA_W-1:0]     in_data,
    output logic                        out_valid,
    output logic [OUT_PAIRS*OUT_W-1:0]  out_i,
    output logic [OUT_PAIRS*OUT_W-1:0]  out_q
);

    localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [OUT_W-1:0] lane_i [LANES];
    logic signed [OUT_W-1:0] lane_q [LANES];
    logic signed [OUT_W-1:0] r_i    [OUT_PAIRS];
    logic signed [OUT_W-1:0] r_q    [OUT_PAIRS];
    logic                    r_v;

    if (!PARALLEL) begin : g_serial
        phase_e ph;

        iqd_phase u_phase (
            .clk (clk),
            .rst (rst),
            .adv (in_valid),
            .ph  (ph)
        );

        iqd_lane #(.DATA_W(DATA_W)) u_lane (
            .ph  (ph),
            .x   (in_data),
            .i_o (lane_i[0]),
            .q_o (lane_q[0])
        );

        if (DECIMATE) begin : g_dec
            logic signed [OUT_W-1:0] held_i;

            always_ff @(posedge clk) begin
                if (rst) begin
                    held_i <= '0;
                    r_i[0] <= '0;
                    r_q[0] <= '0;
                    r_v    <= 1'b0;
                end else begin
                    r_v <= 1'b0;
                    if (in_valid) begin
                        if (!ph[0]) begin
                            held_i <= lane_i[0];
                        end else begin
                            r_i[0] <= held_i;
                            r_q[0] <= lane_q[0];
                            r_v    <= 1'b1;
                        end
                    end
                end
            end

            AST_DECIM_RATE: assert property (@(posedge clk) disable iff (rst)
                out_valid |=> !out_valid); // R4
        end else begin : g_full
            always_ff @(posedge clk) begin
                if (rst) begin
                    r_i[0] <= '0;
                    r_q[0] <= '0;
                    r_v    <= 1'b0;
                end else begin
                    r_v <= in_valid;
                    if (in_valid) begin
                        r_i[0] <= lane_i[0];
                        r_q[0] <= lane_q[0];
                    end
                end
            end

            AST_ONE_ARM: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> (out_i == '0) || (out_q == '0)); // R2
        end
    end else begin : g_parallel
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            iqd_lane #(.DATA_W(DATA_W)) u_lane (
                .ph  (phase_e'(k)),
                .x   (in_data[k*DATA_W +: DATA_W]),
                .i_o (lane_i[k]),
                .q_o (lane_q[k])
            );
        end

        always_ff @(posedge clk) begin
            if (rst) r_v <= 1'b0;
            else     r_v <= in_valid;
        end

        for (genvar p = 0; p < OUT_PAIRS; p++) begin : g_pair
            localparam int SRC_I = DECIMATE ? 2 * p     : p;
            localparam int SRC_Q = DECIMATE ? 2 * p + 1 : p;

            always_ff @(posedge clk) begin
                if (rst) begin
                    r_i[p] <= '0;
                    r_q[p] <= '0;
                end else if (in_valid) begin
                    r_i[p] <= lane_i[SRC_I];
                    r_q[p] <= lane_q[SRC_Q];
                end
            end
        end
    end

    for (genvar p = 0; p < OUT_PAIRS; p++) begin : g_pack
        assign out_i[p*OUT_W +: OUT_W] = r_i[p];
        assign out_q[p*OUT_W +: OUT_W] = r_q[p];

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            (out_i[p*OUT_W +: OUT_W] != MOST_NEG) && (out_q[p*OUT_W +: OUT_W] != MOST_NEG)); // R3
    end

    assign out_valid = r_v;

    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> ($stable(out_i) && $stable(out_q))); // R8

endmodule

// File: tb/tb_iq_quarter_demod.sv
`timescale 1ns/1ps
module tb_iq_quarter_demod;

    localparam int DW = 8;
    localparam int OW = DW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic            s_valid = 1'b0;
    logic [DW-1:0]   s_data  = '0;
    logic            p_valid = 1'b0;
    logic [4*DW-1:0] p_data  = '0;

    logic            d_v, f_v, pd_v, pf_v;
    logic [OW-1:0]   d_i, d_q, f_i, f_q;
    logic [2*OW-1:0] pd_i, pd_q;
    logic [4*OW-1:0] pf_i, pf_q;

    iq_quarter_demod #(.DATA_W(DW), .PARALLEL(1'b0), .DECIMATE(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_data(s_data),
        .out_valid(d_v), .out_i(d_i), .out_q(d_q));

    iq_quarter_demod #(.DATA_W(DW), .PARALLEL(1'b0), .DECIMATE(1'b0)) dut_full (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_data(s_data),
        .out_valid(f_v), .out_i(f_i), .out_q(f_q));

    iq_quarter_demod #(.DATA_W(DW), .PARALLEL(1'b1), .DECIMATE(1'b1)) dut_par (
        .clk(clk), .rst(rst), .in_valid(p_valid), .in_data(p_data),
        .out_valid(pd_v), .out_i(pd_i), .out_q(pd_q));

    iq_quarter_demod #(.DATA_W(DW), .PARALLEL(1'b1), .DECIMATE(1'b0)) dut_parf (
        .clk(clk), .rst(rst), .in_valid(p_valid), .in_data(p_data),
        .out_valid(pf_v), .out_i(pf_i), .out_q(pf_q));

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic int mixi(int v, int n);
        case (n % 4)
            0:       return v;
            2:       return -v;
            default: return 0;
        endcase
    endfunction

    function automatic int mixq(int v, int n);
        case (n % 4)
            1:       return -v;
            3:       return v;
            default: return 0;
        endcase
    endfunction

    function automatic int sx(logic [OW-1:0] b);
        return int'($signed(b));
    endfunction

    // reference model state
    int sidx, s_held;
    bit ed_v, ef_v, ep_v;
    int ed_i, ed_q, ef_i, ef_q;
    int epd_i [2];
    int epd_q [2];
    int epf_i [4];
    int epf_q [4];

    always @(posedge clk) begin
        int v;
        if (rst) begin
            sidx <= 0; s_held <= 0;
            ed_v <= 0; ef_v <= 0; ep_v <= 0;
            ed_i <= 0; ed_q <= 0; ef_i <= 0; ef_q <= 0;
            for (int k = 0; k < 4; k++) begin epf_i[k] <= 0; epf_q[k] <= 0; end
            for (int k = 0; k < 2; k++) begin epd_i[k] <= 0; epd_q[k] <= 0; end
        end else begin
            ed_v <= 1'b0;
            ef_v <= s_valid;
            ep_v <= p_valid;
            if (s_valid) begin
                v = int'($signed(s_data));
                ef_i <= mixi(v, sidx);
                ef_q <= mixq(v, sidx);
                if (sidx % 2 == 0) begin
                    s_held <= mixi(v, sidx);
                end else begin
                    ed_v <= 1'b1;
                    ed_i <= s_held;
                    ed_q <= mixq(v, sidx);
                end
                sidx <= sidx + 1;
            end
            if (p_valid) begin
                for (int k = 0; k < 4; k++) begin
                    v = int'($signed(p_data[k*DW +: DW]));
                    epf_i[k] <= mixi(v, k);
                    epf_q[k] <= mixq(v, k);
                end
                for (int p = 0; p < 2; p++) begin
                    epd_i[p] <= mixi(int'($signed(p_data[(2*p)*DW +: DW])), 2*p);
                    epd_q[p] <= mixq(int'($signed(p_data[(2*p+1)*DW +: DW])), 2*p+1);
                end
            end
        end
    end

    task automatic chk(string tag, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: got %0d expected %0d", tag, what, $time, got, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R4", "dec valid", int'(d_v), int'(ed_v));
            chk("R4", "dec I", sx(d_i), ed_i);
            chk("R4", "dec Q", sx(d_q), ed_q);
            chk("R2", "full valid", int'(f_v), int'(ef_v));
            chk("R2", "full I", sx(f_i), ef_i);
            chk("R2", "full Q", sx(f_q), ef_q);
            chk("R7", "par dec valid", int'(pd_v), int'(ep_v));
            for (int p = 0; p < 2; p++) begin
                chk("R7", "par dec I", sx(pd_i[p*OW +: OW]), epd_i[p]);
                chk("R7", "par dec Q", sx(pd_q[p*OW +: OW]), epd_q[p]);
            end
            chk("R6", "par full valid", int'(pf_v), int'(ep_v));
            for (int k = 0; k < 4; k++) begin
                chk("R6", "par full I", sx(pf_i[k*OW +: OW]), epf_i[k]);
                chk("R6", "par full Q", sx(pf_q[k*OW +: OW]), epf_q[k]);
            end
        end
    end

    task automatic cyc(bit sv, logic [DW-1:0] sd, bit pv, logic [4*DW-1:0] pd);
        @(negedge clk);
        s_valid = sv; s_data = sd;
        p_valid = pv; p_data = pd;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: got hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset valid", int'(d_v | f_v | pd_v | pf_v), 0);
        chk("R1", "reset data", sx(d_i) | sx(f_q) | int'(pd_i) | int'(pf_q), 0);
        rst = 1'b0;

        // R2/R4/R6/R7: contiguous ramp
        for (int n = 0; n < 16; n++)
            cyc(1'b1, DW'(n * 7 + 3), 1'b1, {DW'(n + 40), DW'(n + 30), DW'(n + 20), DW'(n + 10)});
        cyc(1'b0, '0, 1'b0, '0);

        // R5/R8: gaps between samples
        for (int n = 0; n < 24; n++)
            cyc(n % 3 != 1, DW'(n * 11 - 50), n % 2 == 0, {DW'(n), DW'(-n), DW'(n * 3), DW'(n * 5)});
        cyc(1'b0, '0, 1'b0, '0);
        cyc(1'b0, '0, 1'b0, '0);

        // R3: full-scale extremes
        for (int n = 0; n < 12; n++)
            cyc(1'b1, (n % 3 == 2) ? 8'h7F : 8'h80, 1'b1,
                (n % 2 == 0) ? 32'h80808080 : 32'h7F807F80);
        cyc(1'b0, '0, 1'b0, '0);

        // R1: reset after an odd number of samples, then restart at index zero
        for (int n = 0; n < 7; n++)
            cyc(1'b1, DW'(n + 90), 1'b1, {4{DW'(n)}});
        @(negedge clk); rst = 1'b1; s_valid = 1'b0; p_valid = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset valid", int'(d_v | f_v | pd_v | pf_v), 0);
        rst = 1'b0;
        for (int n = 0; n < 8; n++)
            cyc(1'b1, DW'(n + 1), 1'b1, {DW'(4), DW'(3), DW'(2), DW'(1)});
        cyc(1'b0, '0, 1'b0, '0);

        // mixed random traffic
        for (int n = 0; n < 400; n++)
            cyc($urandom_range(0, 3) != 0, DW'($urandom), $urandom_range(0, 1) == 1, 32'($urandom));
        cyc(1'b0, '0, 1'b0, '0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule